// File: doc/BRIEF.md
# Segmented Load/Store Unit with Misaligned Word Splitting

This block connects a 16-bit processor core to a memory bus that carries one 16-bit word per transfer and is addressed in words. The core loads an offset register and a data register, then issues a one-cycle `go` pulse. The pulse carries the access width (byte or word) and the direction. The block adds the segment base, shifted up by four bits, to the offset. That gives a physical byte address one bit wider than the shifted base, so the sum never wraps. The bus address is that byte address with its lowest bit dropped.

Byte accesses and even-addressed word accesses take one bus transfer. A word access at an odd byte address is split into two transfers. The first covers the high lane of word W and the second covers the low lane of word W+1, with the request line dropped for at least one cycle between them. On reads, the lanes are reassembled in the data register. On writes, the data register bytes are steered to the lanes that are selected. A one-cycle `done` pulse follows the last acknowledge.

Top module: `seg_lsu`

## Requirements
- R1: The physical byte address is A = (seg_base << 4) + offset, computed without wrap to 21 bits. While idle, `bus_addr` equals A >> 1. A word access at offset 0xFFFF with base 0 reaches word 0x8000 on its second transfer.
- R2: A one-cycle `ofs_load` loads `ofs_in` into the offset register. A one-cycle `dat_load` loads `dat_in` into the data register, which is visible on `dat_out` in the next cycle.
- R3: A word access at an even A makes one transfer at word A >> 1 with `bus_lanes` = 2'b11. A read returns the whole bus word, and a write drives the whole data register.
- R4: A byte access makes one transfer at word A >> 1. `bus_lanes` is 2'b01 when A is even and 2'b10 when A is odd. A read returns {8'h00, byte at A}, taken from bus bits 7:0 (even) or 15:8 (odd). A write places data register bits 7:0 on the selected lane and changes no other byte.
- R5: A word access at an odd A makes exactly two transfers. The first is at word A >> 1 with lanes 2'b10, and the second is at word (A >> 1) + 1 with lanes 2'b01. `bus_req` is low for at least one cycle between them.
- R6: A split read returns {byte at A+1, byte at A}. A split write stores data bits 7:0 at A and bits 15:8 at A+1, and leaves bytes A-1 and A+2 unchanged.
- R7: `bus_req` stays high until `bus_ack` is seen, across any number of wait cycles. An acknowledge while no request is open has no effect.
- R8: `done` is high for exactly one cycle, in the cycle after the final acknowledge. For reads, `dat_out` holds the result in that cycle.
- R9: While reset is asserted, `done`, `bus_req`, `bus_we` and `bus_lanes` are all zero.
- R10: If `dat_load` falls in the same cycle as the final read acknowledge, the data register takes the read result and the load is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seg_base | input | 16 | Segment base value |
| ofs_in | input | 16 | Offset register load value |
| ofs_load | input | 1 | Load strobe for the offset register |
| dat_in | input | 16 | Data register load value |
| dat_load | input | 1 | Load strobe for the data register |
| go | input | 1 | One-cycle access start |
| byte_mode | input | 1 | 1 = byte access, 0 = word access; sampled with go |
| is_write | input | 1 | 1 = write, 0 = read; sampled with go |
| dat_out | output | 16 | Data register contents |
| done | output | 1 | One-cycle end-of-access strobe |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Transfer is a write |
| bus_addr | output | 20 | Word address |
| bus_wdata | output | 16 | Write data, lane-steered |
| bus_lanes | output | 2 | Byte lane selects, bit 0 = even byte, bit 1 = odd byte |
| bus_rdata | input | 16 | Read data from memory |
| bus_ack | input | 1 | One-cycle transfer acknowledge |

## Verification
The data register has two writers: a host load and the capture of a completed read. Both can be active in the same cycle. To provoke this, the bench memory model raises `dat_load` with a marker value on exactly the edge where it returns the final read acknowledge. The case is judged by requiring `dat_out` in the `done` cycle to equal the assembled memory bytes and not the marker. The bench also sweeps bases, offsets, widths, directions and wait-state counts, and predicts every address, lane pattern and byte from the address arithmetic.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int BYTE_W = 8;
  localparam int LANE_N = 2;
  localparam int WORD_W = BYTE_W * LANE_N;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ1,
    ST_GAP,
    ST_REQ2,
    ST_DONE
  } lsu_state_e;

  typedef struct packed {
    logic byte_mode;
    logic is_write;
    logic odd;
  } acc_attr_t;
endpackage

// File: rtl/lsu_rst_sync.sv
module lsu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PHYS_W    = SEG_W + SEG_SHIFT + 1
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFS_W-1:0]  ofs,
  output logic [PHYS_W-1:0] phys
);
  localparam int SEG_PAD = PHYS_W - SEG_W - SEG_SHIFT;
  localparam int OFS_PAD = PHYS_W - OFS_W;

  logic [PHYS_W-1:0] seg_ext;
  logic [PHYS_W-1:0] ofs_ext;

  assign seg_ext = {{SEG_PAD{1'b0}}, seg, {SEG_SHIFT{1'b0}}};
  assign ofs_ext = {{OFS_PAD{1'b0}}, ofs};
  // One spare bit above the shifted base keeps the sum from wrapping.
  assign phys    = seg_ext + ofs_ext;
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int PHYS_W = 21,
  localparam int BUS_AW = PHYS_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              byte_mode,
  input  logic              is_write,
  input  logic [PHYS_W-1:0] phys_now,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic              bus_we,
  output logic              second,
  output logic              part_load,
  output logic              capture,
  output logic              done,
  output logic              acc_byte,
  output logic              acc_odd,
  output logic [BUS_AW-1:0] acc_word
);
  lsu_state_e        st_q, st_d;
  acc_attr_t         attr_q;
  logic [BUS_AW-1:0] word_q;
  logic              lat_en;
  logic              split;
  logic              final_ack;

  assign lat_en = (st_q == ST_IDLE) && go;
  assign split  = !attr_q.byte_mode && attr_q.odd;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (go)      st_d = ST_REQ1;
      ST_REQ1: if (bus_ack) st_d = split ? ST_GAP : ST_DONE;
      ST_GAP:               st_d = ST_REQ2;
      ST_REQ2: if (bus_ack) st_d = ST_DONE;
      ST_DONE:              st_d = ST_IDLE;
      default:              st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= '0;
      word_q <= '0;
    end else if (lat_en) begin
      attr_q <= '{byte_mode: byte_mode, is_write: is_write, odd: phys_now[0]};
      word_q <= phys_now[PHYS_W-1:1];
    end
  end

  assign bus_req   = (st_q == ST_REQ1) || (st_q == ST_REQ2);
  assign bus_we    = bus_req && attr_q.is_write;
  assign second    = (st_q == ST_REQ2);
  assign final_ack = bus_ack && (((st_q == ST_REQ1) && !split) || (st_q == ST_REQ2));
  assign capture   = final_ack && !attr_q.is_write;
  assign part_load = bus_ack && (st_q == ST_REQ1) && split && !attr_q.is_write;
  assign done      = (st_q == ST_DONE);
  assign acc_byte  = attr_q.byte_mode;
  assign acc_odd   = attr_q.odd;
  assign acc_word  = word_q;

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req)
    else $error("request dropped before acknowledge");

  p_ack_drops_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req)
    else $error("request not released after acknowledge");

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done wider than one cycle");

  p_done_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_req && bus_ack))
    else $error("done without a preceding acknowledge");
endmodule

// File: rtl/lsu_steer.sv
module lsu_steer
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_byte,
  input  logic              acc_odd,
  input  logic              second,
  input  logic              bus_req,
  input  logic              part_load,
  input  logic [WORD_W-1:0] dat_q,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] bus_wdata,
  output logic [LANE_N-1:0] bus_lanes,
  output logic [WORD_W-1:0] merged
);
  logic [BYTE_W-1:0] lo_byte, hi_byte, rd_lo, rd_hi, part_q;

  assign lo_byte = dat_q[BYTE_W-1:0];
  assign hi_byte = dat_q[WORD_W-1:BYTE_W];
  assign rd_lo   = bus_rdata[BYTE_W-1:0];
  assign rd_hi   = bus_rdata[WORD_W-1:BYTE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         part_q <= '0;
    else if (part_load) part_q <= rd_hi;
  end

  always_comb begin
    bus_lanes = '0;
    if (bus_req) begin
      if (acc_byte)     bus_lanes = acc_odd ? 2'b10 : 2'b01;
      else if (!acc_odd) bus_lanes = 2'b11;
      else              bus_lanes = second ? 2'b01 : 2'b10;
    end
  end

  always_comb begin
    if (acc_byte)      bus_wdata = {lo_byte, lo_byte};
    else if (!acc_odd) bus_wdata = dat_q;
    else               bus_wdata = {lo_byte, hi_byte};
  end

  always_comb begin
    if (acc_byte)      merged = {{BYTE_W{1'b0}}, acc_odd ? rd_hi : rd_lo};
    else if (!acc_odd) merged = bus_rdata;
    else               merged = {rd_lo, part_q};
  end
endmodule

// File: rtl/seg_lsu.sv
module seg_lsu
  import lsu_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = SEG_W + SEG_SHIFT + 1,
  localparam int BUS_AW   = PHYS_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEG_W-1:0]  seg_base,
  input  logic [OFS_W-1:0]  ofs_in,
  input  logic              ofs_load,
  input  logic [WORD_W-1:0] dat_in,
  input  logic              dat_load,
  input  logic              go,
  input  logic              byte_mode,
  input  logic              is_write,
  output logic [WORD_W-1:0] dat_out,
  output logic              done,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [WORD_W-1:0] bus_wdata,
  output logic [LANE_N-1:0] bus_lanes,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  logic              rst_n_i;
  logic [OFS_W-1:0]  ofs_q;
  logic [WORD_W-1:0] dat_q;
  logic [PHYS_W-1:0] phys;
  logic [BUS_AW-1:0] acc_word;
  logic [WORD_W-1:0] merged;
  logic              second, part_load, capture, acc_byte, acc_odd;

  lsu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_i)
  );

  lsu_addr_gen #(
    .SEG_W(SEG_W), .OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .PHYS_W(PHYS_W)
  ) u_addr (
    .seg(seg_base), .ofs(ofs_q), .phys(phys)
  );

  lsu_ctrl #(.PHYS_W(PHYS_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .go(go), .byte_mode(byte_mode),
    .is_write(is_write), .phys_now(phys), .bus_ack(bus_ack),
    .bus_req(bus_req), .bus_we(bus_we), .second(second),
    .part_load(part_load), .capture(capture), .done(done),
    .acc_byte(acc_byte), .acc_odd(acc_odd), .acc_word(acc_word)
  );

  lsu_steer u_steer (
    .clk(clk), .rst_n(rst_n_i), .acc_byte(acc_byte), .acc_odd(acc_odd),
    .second(second), .bus_req(bus_req), .part_load(part_load),
    .dat_q(dat_q), .bus_rdata(bus_rdata), .bus_wdata(bus_wdata),
    .bus_lanes(bus_lanes), .merged(merged)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)      ofs_q <= '0;
    else if (ofs_load) ofs_q <= ofs_in;
  end

  // Read capture outranks a host load landing in the same cycle.
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)      dat_q <= '0;
    else if (capture)  dat_q <= merged;
    else if (dat_load) dat_q <= dat_in;
  end

  always_comb begin
    if (second)       bus_addr = acc_word + {{(BUS_AW-1){1'b0}}, 1'b1};
    else if (bus_req) bus_addr = acc_word;
    else              bus_addr = phys[PHYS_W-1:1];
  end

  assign dat_out = dat_q;

  p_lanes_live_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    bus_req |-> bus_lanes != '0)
    else $error("request with no lane selected");

  p_capture_wins_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    capture |=> dat_out == $past(merged))
    else $error("read result lost");
endmodule

// File: tb/seg_lsu_bench.sv
`timescale 1ns/1ps
module seg_lsu_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] seg_base, ofs_in, tb_din, coll_data, dat_in, dat_out;
  logic        ofs_load, tb_dload, coll_load, dat_load, go, byte_mode, is_write;
  logic        done, bus_req, bus_we, mem_ack, stray_ack, bus_ack;
  logic [19:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [1:0]  bus_lanes;

  always #2.5 clk = ~clk;

  assign dat_load = tb_dload | coll_load;
  assign dat_in   = coll_load ? coll_data : tb_din;
  assign bus_ack  = mem_ack | stray_ack;

  seg_lsu u_seg_lsu (
    .clk(clk), .rst_n(rst_n), .seg_base(seg_base), .ofs_in(ofs_in),
    .ofs_load(ofs_load), .dat_in(dat_in), .dat_load(dat_load), .go(go),
    .byte_mode(byte_mode), .is_write(is_write), .dat_out(dat_out),
    .done(done), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_lanes(bus_lanes), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] mem_ov [int];
  int  wait_cfg = 0;
  int  wcnt = 0;
  int  tr_n = 0;
  int  tr_addr [4];
  int  tr_lanes [4];
  bit  gap_seen = 0;
  bit  coll_arm = 0;

  function automatic logic [7:0] init_b(int a);
    return 8'((a * 37) ^ (a >> 7) ^ 8'h5A);
  endfunction

  function automatic logic [7:0] mem_rd(int a);
    if (mem_ov.exists(a)) return mem_ov[a];
    return init_b(a);
  endfunction

  always @(negedge clk) begin
    if (tr_n == 1 && bus_req === 1'b0) gap_seen = 1;
    if (mem_ack) begin
      mem_ack   = 1'b0;
      coll_load = 1'b0;
    end else if (bus_req === 1'b1) begin
      if (wcnt >= wait_cfg) begin
        automatic int a = int'(bus_addr) * 2;
        bus_rdata = {mem_rd(a + 1), mem_rd(a)};
        if (bus_we === 1'b1) begin
          if (bus_lanes[0]) mem_ov[a]     = bus_wdata[7:0];
          if (bus_lanes[1]) mem_ov[a + 1] = bus_wdata[15:8];
        end
        if (tr_n < 4) begin
          tr_addr[tr_n]  = int'(bus_addr);
          tr_lanes[tr_n] = int'(bus_lanes);
        end
        tr_n++;
        mem_ack = 1'b1;
        wcnt = 0;
        if (coll_arm) begin
          coll_load = 1'b1;
          coll_arm  = 1'b0;
        end
      end else wcnt++;
    end else wcnt = 0;
  end

  // ---------------- helpers ----------------
  task automatic load_ofs(input logic [15:0] v);
    @(negedge clk); ofs_in = v; ofs_load = 1'b1;
    @(negedge clk); ofs_load = 1'b0;
  endtask

  task automatic load_dat(input logic [15:0] v);
    @(negedge clk); tb_din = v; tb_dload = 1'b1;
    @(negedge clk); tb_dload = 1'b0;
  endtask

  task automatic run_acc(input bit bm, input bit wr, output bit ok,
                         output logic [15:0] res, output bit wide);
    tr_n = 0; gap_seen = 0; ok = 0; wide = 0; res = '0;
    @(negedge clk); go = 1'b1; byte_mode = bm; is_write = wr;
    @(negedge clk); go = 1'b0;
    for (int c = 0; c < 60; c++) begin
      if (done === 1'b1) begin ok = 1; break; end
      @(negedge clk);
    end
    res = dat_out;
    @(negedge clk);
    wide = (done !== 1'b0);
  endtask

  function automatic logic [15:0] seg_of(int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0800;
      2: return 16'hFFFF;
      default: return 16'h1234;
    endcase
  endfunction

  function automatic logic [15:0] ofs_of(int i);
    case (i)
      0: return 16'h0100;
      1: return 16'h0101;
      2: return 16'hFFFE;
      3: return 16'hFFFF;
      default: return 16'h07A3;
    endcase
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    #900000;
    n_run++; n_fail++;
    $display("FAIL R8 watchdog act=%h exp=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    bit ok, wide;
    logic [15:0] res, d;
    int k;
    rst_n = 1'b0; seg_base = '0; ofs_in = '0; tb_din = '0; coll_data = '0;
    ofs_load = 0; tb_dload = 0; coll_load = 0; go = 0; byte_mode = 0;
    is_write = 0; mem_ack = 0; stray_ack = 0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R9 done", 32'(done), 0);
    chk("R9 bus_req", 32'(bus_req), 0);
    chk("R9 bus_we", 32'(bus_we), 0);
    chk("R9 lanes", 32'(bus_lanes), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    load_dat(16'hC3A5);
    chk("R2 data load", 32'(dat_out), 32'hC3A5);
    load_dat(16'h0F1E);
    chk("R2 data reload", 32'(dat_out), 32'h0F1E);

    k = 0;
    for (int si = 0; si < 4; si++) begin
      for (int oi = 0; oi < 5; oi++) begin
        for (int bm = 0; bm < 2; bm++) begin
          for (int wr = 0; wr < 2; wr++) begin
            automatic int A, W;
            automatic logic [7:0] b_prev, b_next, b_next2;
            automatic string at;
            seg_base = seg_of(si);
            load_ofs(ofs_of(oi));
            A = (int'(seg_base) << 4) + int'(ofs_of(oi));
            W = A >> 1;
            chk("R1 idle addr", 32'(bus_addr), 32'(W));
            d = {8'(si * 16 + oi + 8'h30), 8'(bm * 8'h40 + oi * 7 + 8'h11 + wr)};
            if (wr) load_dat(d);
            b_prev = mem_rd(A - 1); b_next = mem_rd(A + 1); b_next2 = mem_rd(A + 2);
            wait_cfg = k % 4; k++;
            run_acc(bm[0], wr[0], ok, res, wide);
            chk("R8 done seen", 32'(ok), 1);
            chk("R8 done width", 32'(wide), 0);
            if (bm) begin
              chk("R4 count", 32'(tr_n), 1);
              chk("R4 addr", 32'(tr_addr[0]), 32'(W));
              chk("R4 lanes", 32'(tr_lanes[0]), (A & 1) ? 2 : 1);
              if (wr) begin
                chk("R4 byte stored", 32'(mem_rd(A)), 32'(d[7:0]));
                chk("R4 next untouched", 32'(mem_rd(A + 1)), 32'(b_next));
                chk("R4 prev untouched", 32'(mem_rd(A - 1)), 32'(b_prev));
              end else
                chk("R4 read byte", 32'(res), 32'({8'h00, mem_rd(A)}));
            end else if ((A & 1) == 0) begin
              chk("R3 count", 32'(tr_n), 1);
              chk("R3 addr", 32'(tr_addr[0]), 32'(W));
              chk("R3 lanes", 32'(tr_lanes[0]), 3);
              if (wr) begin
                chk("R3 low stored", 32'(mem_rd(A)), 32'(d[7:0]));
                chk("R3 high stored", 32'(mem_rd(A + 1)), 32'(d[15:8]));
              end else
                chk("R3 read word", 32'(res), 32'({mem_rd(A + 1), mem_rd(A)}));
            end else begin
              at = (A == 32'hFFFF) ? "R1 split addr" : "R5 split addr";
              chk("R5 count", 32'(tr_n), 2);
              chk("R5 first addr", 32'(tr_addr[0]), 32'(W));
              chk(at, 32'(tr_addr[1]), 32'(W + 1));
              chk("R5 first lanes", 32'(tr_lanes[0]), 2);
              chk("R5 second lanes", 32'(tr_lanes[1]), 1);
              chk("R5 gap", 32'(gap_seen), 1);
              if (wr) begin
                chk("R6 low stored", 32'(mem_rd(A)), 32'(d[7:0]));
                chk("R6 high stored", 32'(mem_rd(A + 1)), 32'(d[15:8]));
                chk("R6 prev untouched", 32'(mem_rd(A - 1)), 32'(b_prev));
                chk("R6 next untouched", 32'(mem_rd(A + 2)), 32'(b_next2));
              end else
                chk("R6 split read", 32'(res), 32'({mem_rd(A + 1), mem_rd(A)}));
            end
          end
        end
      end
    end

    // R10: host load in the same cycle as the final read acknowledge
    seg_base = 16'h0000;
    load_ofs(16'h0200);
    coll_data = 16'hBEEF; coll_arm = 1; wait_cfg = 1;
    run_acc(1'b0, 1'b0, ok, res, wide);
    chk("R10 done seen", 32'(ok), 1);
    chk("R10 read wins", 32'(res), 32'({mem_rd(16'h0201), mem_rd(16'h0200)}));
    coll_arm = 0;

    // R7: stray acknowledge while idle
    load_dat(16'h6B2C);
    @(negedge clk); stray_ack = 1'b1;
    @(negedge clk); stray_ack = 1'b0;
    chk("R7 stray no done", 32'(done), 0);
    chk("R7 stray no req", 32'(bus_req), 0);
    @(negedge clk);
    chk("R7 stray no done later", 32'(done), 0);
    chk("R7 stray data kept", 32'(dat_out), 32'h6B2C);

    // R7: long wait states on a split read
    load_ofs(16'h0301);
    wait_cfg = 7;
    run_acc(1'b0, 1'b0, ok, res, wide);
    chk("R7 long wait done", 32'(ok), 1);
    chk("R7 long wait data", 32'(res), 32'({mem_rd(16'h0302), mem_rd(16'h0301)}));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule